// File: doc/BRIEF.md
# Framed SPI Shift Engine

This block moves one word at a time over a four-wire serial link in which the start of every word is marked by a frame sync pulse one bit clock wide, not by a select line held low for the whole transfer. The engine can drive the bit clock itself as master, or follow a clock from outside as slave. Independently of that choice, it can drive the frame sync pulse or wait for one from the far end. A user loads a parallel word and pulses `start`. `busy` stays high while the word is on the wire. A one-cycle `done` then returns the word that was shifted in.

The link timing is fixed: the clock idles low, outgoing data changes after a falling clock edge, and incoming data is taken on a rising edge. Words go out and come in MSB first. The sync pulse has selectable polarity. It sits either in the bit clock just before the MSB or in the same bit clock as the MSB. In slave mode the external clock, the incoming sync and the incoming data pass through a synchronizer to the system clock. The system clock must therefore run several times faster than the bit clock.

Top module: `fspi_engine`

## Requirements
- R1: After reset, `busy`, `done` and `sck_o` are 0, and `fsync_o` sits at its inactive level: 0 when `cfg_sync_low`=0, and 1 when `cfg_sync_low`=1.
- R2: With `cfg_frame_en`=0, a transfer shifts exactly WORD_W bits MSB first in both directions, and no sync pulse is driven.
- R3: `fsync_oe` is 1 exactly when `cfg_frame_en`=1 and `cfg_sync_in`=0.
- R4: A sync pulse the block drives is active for exactly one bit clock. It is high-active when `cfg_sync_low`=0 and low-active when `cfg_sync_low`=1.
- R5: With `cfg_sync_early`=1, the driven sync pulse occupies the bit clock immediately before the MSB bit clock.
- R6: With `cfg_sync_early`=0, the driven sync pulse occupies the same bit clock as the MSB.
- R7: With `cfg_sync_in`=1, no data is taken until an active sync level on `fsync_i` is seen at a rising clock edge. The MSB is then the next bit clock when `cfg_sync_early`=1, or that same bit clock when it is 0.
- R8: With `cfg_master`=0, bit timing follows `sck_i` and the word begins at the first falling edge of `sck_i` after `start`. A driven sync pulse still works in this mode.
- R9: `done` is high for one system clock at the end of the last bit clock. In that same cycle `rx_word` holds the received word and `busy` is 0.
- R10: A `start` pulse while `busy` is 1 is ignored: the word on the wire and the number of `done` pulses are unchanged.
- R11: In master mode, `sck_o` is low when idle, each half period lasts HALF_DIV system clocks, and `sdo` changes only after falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frame_en | input | 1 | 1 = framed operation with sync pulse |
| cfg_sync_in | input | 1 | 1 = sync pulse received on fsync_i, 0 = driven on fsync_o |
| cfg_sync_low | input | 1 | 1 = sync pulse active low |
| cfg_sync_early | input | 1 | 1 = sync one bit clock before MSB, 0 = aligned with MSB |
| cfg_master | input | 1 | 1 = generate sck_o, 0 = follow sck_i |
| start | input | 1 | One-cycle request to send tx_word |
| tx_word | input | WORD_W | Word to transmit, captured at start |
| rx_word | output | WORD_W | Last received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| sck_o | output | 1 | Bit clock in master mode |
| sck_i | input | 1 | Bit clock in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| fsync_o | output | 1 | Driven frame sync |
| fsync_oe | output | 1 | Enable for fsync_o on the pad |
| fsync_i | input | 1 | Received frame sync |

## Verification
The bench acts as the far end of the link. It decides from the pin-level sync where each word begins, so a pulse placed one slot off makes both the captured transmit word and the returned receive word come out shifted by a bit. An active-low pulse that is never generated, or that lasts two slots, shows up in the count of sync-active rising edges. In sync-input mode the bench holds back the sync for a few clocks: an engine that starts shifting before the sync arrives returns garbage. An aligned-input engine that drops the MSB taken together with the sync is off by one bit. A second `start` during a transfer would corrupt the word or produce an extra `done`. Slave runs that use a free-running external clock show whether the word starts at the correct falling edge.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PRE,
    ST_HUNT,
    ST_DATA,
    ST_TAIL
  } fspi_state_e;

  localparam int PIN_SCK  = 0;
  localparam int PIN_SDI  = 1;
  localparam int PIN_FS   = 2;
  localparam int PIN_CNT  = 3;
endpackage

// File: rtl/fspi_pinsync.sv
module fspi_pinsync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [N-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_prev <= '0;
    else     q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fspi_clkgen.sv
module fspi_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic lead,
  output logic trail
);
  localparam int DW = $clog2(HALF_DIV) + 1;
  localparam logic [DW-1:0] TOP = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt;
  logic          hi;
  logic          was_run;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else if (cnt == TOP) begin
      cnt <= '0;
      hi  <= ~hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) was_run <= 1'b0;
    else     was_run <= run;
  end

  assign sck   = hi;
  assign lead  = run && (!was_run || (cnt == TOP && hi));
  assign trail = run && cnt == TOP && !hi;

  p_sck_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);
  p_half_len_r11: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $rose(sck)) |-> $past(cnt) == TOP);
endmodule

// File: rtl/fspi_shifter.sv
module fspi_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              shift,
  input  logic              cap,
  input  logic              sdi_bit,
  output logic              sdo,
  output logic [WORD_W-1:0] rx_sh,
  output logic              last
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] tx_q;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst)        tx_q <= '0;
    else if (load)  tx_q <= tx_word;
    else if (shift) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)      rx_sh <= '0;
    else if (cap) rx_sh <= {rx_sh[WORD_W-2:0], sdi_bit};
  end

  always_ff @(posedge clk) begin
    if (rst || load) cnt <= '0;
    else if (cap)    cnt <= cnt + 1'b1;
  end

  assign sdo  = tx_q[WORD_W-1];
  assign last = cap && (cnt == LAST_IDX);

  p_no_shift_on_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == '0);
endmodule

// File: rtl/fspi_engine.sv
module fspi_engine
  import fspi_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_frame_en,
  input  logic              cfg_sync_in,
  input  logic              cfg_sync_low,
  input  logic              cfg_sync_early,
  input  logic              cfg_master,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo,
  input  logic              sdi,
  output logic              fsync_o,
  output logic              fsync_oe,
  input  logic              fsync_i
);
  fspi_state_e state;

  logic [PIN_CNT-1:0] pin_raw, pin_q, pin_qd;
  logic m_lead, m_trail, m_sck;
  logic s_lead, s_trail;
  logic slot_start, sample;
  logic sync_seen;
  logic fs_act;
  logic pend;
  logic load, shift, cap, last;
  logic [WORD_W-1:0] rx_sh;
  logic [1:0] fs_samples;

  always_comb begin
    pin_raw          = '0;
    pin_raw[PIN_SCK] = sck_i;
    pin_raw[PIN_SDI] = sdi;
    pin_raw[PIN_FS]  = fsync_i;
  end

  fspi_pinsync #(.N(PIN_CNT), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(pin_raw), .q(pin_q), .q_prev(pin_qd)
  );

  fspi_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(busy && cfg_master),
    .sck(m_sck), .lead(m_lead), .trail(m_trail)
  );

  assign s_lead  = !pin_q[PIN_SCK] &&  pin_qd[PIN_SCK];
  assign s_trail =  pin_q[PIN_SCK] && !pin_qd[PIN_SCK];

  assign slot_start = cfg_master ? m_lead  : s_lead;
  assign sample     = cfg_master ? m_trail : s_trail;
  assign sync_seen  = pin_q[PIN_FS] ^ cfg_sync_low;

  assign load  = (state == ST_IDLE) && start;
  assign shift = (state == ST_DATA) && slot_start && pend;
  assign cap   = sample && ((state == ST_DATA) ||
                 ((state == ST_HUNT) && sync_seen && !cfg_sync_early));

  fspi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .tx_word(tx_word),
    .shift(shift), .cap(cap), .sdi_bit(pin_q[PIN_SDI]),
    .sdo(sdo), .rx_sh(rx_sh), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      fs_act  <= 1'b0;
      pend    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            pend  <= 1'b0;
            state <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (slot_start) begin
            if (!cfg_frame_en) begin
              state <= ST_DATA;
            end else if (cfg_sync_in) begin
              state <= ST_HUNT;
            end else begin
              fs_act <= 1'b1;
              state  <= cfg_sync_early ? ST_PRE : ST_DATA;
            end
          end
        end
        ST_PRE: begin
          if (slot_start) begin
            fs_act <= 1'b0;
            state  <= ST_DATA;
          end
        end
        ST_HUNT: begin
          if (sample && sync_seen) begin
            pend  <= !cfg_sync_early;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (slot_start) begin
            fs_act <= 1'b0;
            if (pend) pend <= 1'b0;
          end
          if (sample) begin
            pend <= 1'b1;
            if (last) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (slot_start) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            fs_act  <= 1'b0;
            rx_word <= rx_sh;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !fs_act)   fs_samples <= '0;
    else if (sample && fs_samples != 2'd3) fs_samples <= fs_samples + 1'b1;
  end

  assign sck_o    = cfg_master ? m_sck : 1'b0;
  assign fsync_o  = fs_act ^ cfg_sync_low;
  assign fsync_oe = cfg_frame_en && !cfg_sync_in;

  p_sync_width_r4: assert property (@(posedge clk) disable iff (rst)
    fs_samples < 2'd2);
  p_unframed_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_frame_en |-> !fs_act);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(state) == ST_TAIL);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (start && busy && state != ST_IDLE) |=> state != ST_ARM);
endmodule

// File: tb/sim_fspi_engine.sv
module sim_fspi_engine;
  localparam int W = 8;
  localparam int HD = 4;

  logic clk = 0, rst = 1;
  logic cfg_frame_en = 0, cfg_sync_in = 0, cfg_sync_low = 0;
  logic cfg_sync_early = 0, cfg_master = 1;
  logic start = 0;
  logic [W-1:0] tx_word = '0, rx_word;
  logic busy, done, sck_o, sdo, fsync_o, fsync_oe;
  logic bsck = 0, sdi = 0, bfs = 0;

  int total = 0, bad = 0;
  logic [W-1:0] exp_q[$];
  int done_cnt = 0;

  logic armed = 0, fall_seen = 0, data_on = 0, prev_sync = 0, took = 0;
  int ridx = 0, p = 0, sync_rises = 0, falls = 0, sync_at = 3;
  logic [W-1:0] peer_word = '0, cap_tx = '0;

  always #10 clk = ~clk;
  initial begin #5; forever #160 bsck = ~bsck; end

  fspi_engine #(.WORD_W(W), .HALF_DIV(HD)) u0 (
    .clk(clk), .rst(rst), .cfg_frame_en(cfg_frame_en), .cfg_sync_in(cfg_sync_in),
    .cfg_sync_low(cfg_sync_low), .cfg_sync_early(cfg_sync_early),
    .cfg_master(cfg_master), .start(start), .tx_word(tx_word), .rx_word(rx_word),
    .busy(busy), .done(done), .sck_o(sck_o), .sck_i(bsck), .sdo(sdo), .sdi(sdi),
    .fsync_o(fsync_o), .fsync_oe(fsync_oe), .fsync_i(bfs)
  );

  wire pin_sck = cfg_master ? sck_o : bsck;
  wire pin_fs  = fsync_oe ? fsync_o : bfs;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // far-end peer: samples on rising edge, launches on falling edge
  always @(posedge pin_sck) begin
    #2;
    if (armed) begin
      logic act;
      act = pin_fs ^ cfg_sync_low;
      if (act) sync_rises++;
      if (!data_on) begin
        if (!cfg_frame_en) data_on = fall_seen;
        else if (!cfg_sync_early) data_on = act;
        else data_on = prev_sync;
      end
      if (data_on && ridx < W) begin
        cap_tx[W-1-ridx] = sdo;
        ridx++;
        took = 1;
      end
      prev_sync = act;
    end
  end

  always @(negedge pin_sck) begin
    #2;
    if (armed) begin
      fall_seen = 1;
      falls++;
      if (cfg_frame_en && cfg_sync_in) bfs = ((falls == sync_at) ^ cfg_sync_low);
      if (took) begin
        took = 0;
        p++;
        sdi = (p < W) ? peer_word[W-1-p] : 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R9 unexpected done", 1, 0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rx_word == e, "R9 rx_word at done", rx_word, e);
        check(!busy, "R9 busy low at done", busy, 0);
      end
    end
  end

  task automatic xfer(input bit m, input bit fr, input bit sin, input bit pol,
                      input bit early, input logic [W-1:0] txw,
                      input logic [W-1:0] pw, input bit restart, input string req);
    int d0;
    @(negedge clk);
    cfg_master = m; cfg_frame_en = fr; cfg_sync_in = sin;
    cfg_sync_low = pol; cfg_sync_early = early;
    bfs = pol;
    repeat (4) @(negedge clk);
    check(fsync_oe == (fr && !sin), {req, " R3 fsync_oe"}, fsync_oe, fr && !sin);
    if (fr && !sin)
      check(fsync_o == pol, {req, " R4 idle sync level"}, fsync_o, pol);
    if (!m) begin
      @(posedge bsck);
      @(negedge clk);
    end
    peer_word = pw; p = 0; sdi = pw[W-1];
    ridx = 0; sync_rises = 0; falls = 0; data_on = 0; prev_sync = 0; took = 0;
    cap_tx = '0; fall_seen = m;
    d0 = done_cnt;
    exp_q.push_back(pw);
    armed = 1;
    tx_word = txw; start = 1;
    @(negedge clk); start = 0;
    if (restart) begin
      repeat (30) @(negedge clk);
      tx_word = ~txw; start = 1;
      @(negedge clk); start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    armed = 0;
    repeat (40) @(negedge clk);
    check(cap_tx == txw, {req, " tx word on sdo"}, cap_tx, txw);
    check(done_cnt == d0 + 1, {req, " R9 one done"}, done_cnt - d0, 1);
    if (!sin)
      check(sync_rises == (fr ? 1 : 0), {req, " R4 sync width"}, sync_rises, fr ? 1 : 0);
    if (fr && !sin)
      check(fsync_o == pol, {req, " R4 sync back to idle"}, fsync_o, pol);
    bfs = pol;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!sck_o, "R1 sck_o", sck_o, 0);
    check(fsync_o == 1'b0, "R1 fsync_o high-active idle", fsync_o, 0);
    cfg_sync_low = 1;
    @(negedge clk);
    check(fsync_o == 1'b1, "R1 fsync_o low-active idle", fsync_o, 1);
    cfg_sync_low = 0;

    // R2 R11 master unframed
    xfer(1, 0, 0, 0, 0, 8'hA5, 8'h3C, 0, "R2 R11 master plain");
    xfer(1, 0, 0, 0, 0, 8'h81, 8'hFF, 0, "R2 master plain 2");
    // R5 R6 R4 master drives sync, both polarities
    xfer(1, 1, 0, 0, 1, 8'h5A, 8'hC3, 0, "R5 master early high");
    xfer(1, 1, 0, 1, 1, 8'h96, 8'h0F, 0, "R5 R4 master early low");
    xfer(1, 1, 0, 1, 0, 8'h3C, 8'hA5, 0, "R6 R4 master aligned low");
    xfer(1, 1, 0, 0, 0, 8'hF0, 8'h01, 0, "R6 master aligned high");
    // R7 master waits for external sync
    xfer(1, 1, 1, 0, 1, 8'h12, 8'h34, 0, "R7 master sync-in early");
    xfer(1, 1, 1, 1, 0, 8'hE7, 8'h80, 0, "R7 master sync-in aligned");
    // R8 slave clock
    xfer(0, 0, 0, 0, 0, 8'h69, 8'h96, 0, "R8 slave plain");
    xfer(0, 1, 0, 1, 1, 8'hC5, 8'h5C, 0, "R8 R5 slave sync-out early low");
    xfer(0, 1, 0, 0, 0, 8'h0E, 8'hE0, 0, "R8 R6 slave sync-out aligned");
    xfer(0, 1, 1, 0, 0, 8'hB4, 8'h4B, 0, "R8 R7 slave sync-in aligned");
    xfer(0, 1, 1, 1, 1, 8'h7F, 8'h00, 0, "R8 R7 slave sync-in early");
    // R10 start during busy ignored
    xfer(1, 1, 0, 0, 1, 8'hAA, 8'h55, 1, "R10 master restart");
    xfer(0, 0, 0, 0, 0, 8'h33, 8'hCC, 1, "R10 slave restart");
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule